// File: doc/BRIEF.md
# Six-Port GPIO Bank with Pin Sharing

This block is a bank of six general-purpose I/O ports that sit in a banked configuration space. A register is named by an 8-bit offset and an 8-bit logical-device code. Offsets below 0x30 are global and are decoded whatever device code is presented. Offsets from 0x30 upward belong to the logical device named on `devSel`. Three logical devices each own two ports: code 0x09 owns ports 1 and 2, code 0x07 owns ports 3 and 4, and code 0x08 owns ports 5 and 6.

Each port has four pieces of state: a direction byte, a data byte, a polarity-inversion byte, and one enable bit inside its device's enable register at offset 0x30. Two global registers choose push-pull or open-drain drive for each port. Other global fields take pins away from the GPIO function: a 2-bit routing field for port 1, an I2C select that claims two pins of port 2, and a floppy-enable bit that shuts port 6 off.

Register writes take effect at the clock edge. Readback and the pin outputs are combinational from the stored state and the pin inputs.

Top module: `sio_gpio_bank`

## Requirements
- R1: After reset, the implemented direction bits of every port read 1 (input) and every other register reads 0, so no `pinOe` bit is asserted.
- R2: Port registers decode as follows. In device codes 0x09, 0x07 and 0x08, offsets 0xE0/0xE1/0xE2 are the direction, data and inversion registers of the lower port, and 0xE4/0xE5/0xE6 are those of the upper port. Offset 0x30 of each device is its enable register. Any other offset or device code reads 0 and a write to it changes nothing.
- R3: A pin that is available, has direction bit 0 and belongs to a push-pull port asserts `pinOe` and drives the data bit XOR the inversion bit.
- R4: A pin that is available, has direction bit 0 and belongs to an open-drain port drives `pinOut` 0 and asserts `pinOe` only when the data bit XOR the inversion bit is 0. The push-pull select bits are: ports 1 and 2 use bits 6 and 7 of 0x2C; ports 3, 4, 5 and 6 use bits 3, 4, 5 and 7 of 0x29. A clear bit selects open-drain.
- R5: Reading the data register returns, for an available input pin, the pin level XOR its inversion bit, and for an available output pin, the stored data bit.
- R6: A port whose enable bit is clear never asserts `pinOe` and reads 0 from its data register. The enable bits are bits 0 and 1 in device 0x09 (ports 1 and 2), bits 0 and 1 in device 0x07 (ports 3 and 4), and bits 1 and 2 in device 0x08 (ports 5 and 6).
- R7: Port 1 pins are available only while field [1:0] of global 0x2C equals 2. The values 0, 1 and 3 route the pins to other functions.
- R8: While bit 1 of global 0x2A is set, pins 5 and 6 of port 2 are unavailable.
- R9: While bit 1 of global 0x24 is set, port 6 is unavailable.
- R10: Port 6 has pins 0 to 4 only. Bits 7:5 of its direction, data and inversion registers read 0 and ignore writes, and pins 45 to 47 are never driven.
- R11: The global registers 0x24, 0x29, 0x2A and 0x2C hold and read back the full byte for any device code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register offset |
| devSel | input | 8 | Logical device code |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational readback of the addressed register |
| pinIn | input | 48 | Pin levels, port p on bits 8p+7..8p |
| pinOut | output | 48 | Pin output values |
| pinOe | output | 48 | Pin output enables |

## Verification
The bench builds the bank with its default geometry: six ports of eight bit positions, with the last port trimmed to five pins. This geometry is what makes the trimmed port 6 and the three device codes reachable. Random writes land on every mapped offset, on the reserved slots 0xE3 and 0xE7, on an unmapped offset and on unmapped device codes. Random pin levels accompany them. The full 48-bit drive and enable vectors, plus one random readback, are compared after every write. Directed sequences cover each port-1 routing value, the I2C and floppy takeovers, and a push-pull to open-drain change with inversion set.

// File: rtl/sio_gpio_pkg.sv
package sio_gpio_pkg;
  localparam int NUM_PORTS   = 6;
  localparam int PORT_W      = 8;
  localparam int NUM_DEVS    = 3;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;
  localparam int NUM_PINS    = NUM_PORTS * PORT_W;
  localparam int LAST_PINS   = 5;
  localparam int PORT_IDX_W  = $clog2(NUM_PORTS);
  localparam int DEV_IDX_W   = $clog2(NUM_DEVS);

  localparam logic [ADDR_W-1:0] ENABLE_OFS  = 8'h30;
  localparam logic [ADDR_W-1:0] FLOPPY_OFS  = 8'h24;
  localparam logic [ADDR_W-1:0] DRVHI_OFS   = 8'h29;
  localparam logic [ADDR_W-1:0] I2CSEL_OFS  = 8'h2A;
  localparam logic [ADDR_W-1:0] ROUTE_OFS   = 8'h2C;
  localparam logic [1:0]        ROUTE_GPIO  = 2'd2;

  typedef struct packed {
    logic [NUM_PORTS-1:0] dirWr;
    logic [NUM_PORTS-1:0] datWr;
    logic [NUM_PORTS-1:0] invWr;
    logic [NUM_DEVS-1:0]  enWr;
    logic floppyWr;
    logic drvHiWr;
    logic i2cWr;
    logic routeWr;
  } wrStb_t;

  typedef enum logic [2:0] {RD_NONE, RD_DIR, RD_DAT, RD_INV, RD_EN, RD_GLOB} rdKind_t;

  typedef struct packed {
    rdKind_t                kind;
    logic [PORT_IDX_W-1:0]  port;
    logic [DEV_IDX_W-1:0]   dev;
    logic [1:0]             glob;
  } rdSel_t;

  function automatic logic [DATA_W-1:0] devCode(input int d);
    case (d)
      0:       return 8'h09;
      1:       return 8'h07;
      default: return 8'h08;
    endcase
  endfunction

  function automatic int enBit(input int p);
    return (p < 4) ? (p % 2) : (p % 2) + 1;
  endfunction

  function automatic bit drvInRoute(input int p);
    return p < 2;
  endfunction

  function automatic int drvBit(input int p);
    case (p)
      0:       return 6;
      1:       return 7;
      2:       return 3;
      3:       return 4;
      4:       return 5;
      default: return 7;
    endcase
  endfunction

  function automatic logic [PORT_W-1:0] pinMask(input int p);
    return (p == NUM_PORTS - 1) ? PORT_W'((1 << LAST_PINS) - 1) : {PORT_W{1'b1}};
  endfunction
endpackage

// File: rtl/sio_gpio_ctrl.sv
module sio_gpio_ctrl
  import sio_gpio_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] devSel,
  input  logic              wrEn,
  output wrStb_t            stb,
  output rdSel_t            rdSel
);
  logic                  devHit;
  logic [DEV_IDX_W-1:0]  devIdx;
  logic [PORT_IDX_W-1:0] portIdx;
  logic                  inPortWin;

  always_comb begin
    devHit = 1'b0;
    devIdx = '0;
    for (int d = 0; d < NUM_DEVS; d++) begin
      if (devSel == devCode(d)) begin
        devHit = 1'b1;
        devIdx = DEV_IDX_W'(d);
      end
    end
  end

  assign portIdx   = {devIdx, regAddr[2]};
  assign inPortWin = devHit && (regAddr[7:3] == 5'b11100) && (regAddr[1:0] != 2'b11);

  always_comb begin
    stb        = '0;
    rdSel.kind = RD_NONE;
    rdSel.port = portIdx;
    rdSel.dev  = devIdx;
    rdSel.glob = 2'd0;
    if (inPortWin) begin
      case (regAddr[1:0])
        2'd0: begin rdSel.kind = RD_DIR; stb.dirWr[portIdx] = wrEn; end
        2'd1: begin rdSel.kind = RD_DAT; stb.datWr[portIdx] = wrEn; end
        default: begin rdSel.kind = RD_INV; stb.invWr[portIdx] = wrEn; end
      endcase
    end else if (devHit && regAddr == ENABLE_OFS) begin
      rdSel.kind       = RD_EN;
      stb.enWr[devIdx] = wrEn;
    end else begin
      case (regAddr)
        FLOPPY_OFS: begin rdSel.kind = RD_GLOB; rdSel.glob = 2'd0; stb.floppyWr = wrEn; end
        DRVHI_OFS:  begin rdSel.kind = RD_GLOB; rdSel.glob = 2'd1; stb.drvHiWr  = wrEn; end
        I2CSEL_OFS: begin rdSel.kind = RD_GLOB; rdSel.glob = 2'd2; stb.i2cWr    = wrEn; end
        ROUTE_OFS:  begin rdSel.kind = RD_GLOB; rdSel.glob = 2'd3; stb.routeWr  = wrEn; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sio_gpio_dp.sv
module sio_gpio_dp
  import sio_gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  wrStb_t              stb,
  input  rdSel_t              rdSel,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [DATA_W-1:0]   rdData
);
  logic [NUM_PORTS-1:0][PORT_W-1:0] dirR, datR, invR, datRd;
  logic [NUM_DEVS-1:0][DATA_W-1:0]  enR;
  logic [DATA_W-1:0] floppyR, drvHiR, i2cR, routeR;
  logic [NUM_PORTS-1:0] portEn, ppSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      floppyR <= '0;
      drvHiR  <= '0;
      i2cR    <= '0;
      routeR  <= '0;
    end else begin
      if (stb.floppyWr) floppyR <= wrData;
      if (stb.drvHiWr)  drvHiR  <= wrData;
      if (stb.i2cWr)    i2cR    <= wrData;
      if (stb.routeWr)  routeR  <= wrData;
    end
  end

  for (genvar d = 0; d < NUM_DEVS; d++) begin : g_dev
    always_ff @(posedge clk) begin
      if (!rstN)          enR[d] <= '0;
      else if (stb.enWr[d]) enR[d] <= wrData;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [PORT_W-1:0] PMASK = pinMask(p);
    logic [PORT_W-1:0] shareMask, avail, drv, isOut;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dirR[p] <= PMASK;
        datR[p] <= '0;
        invR[p] <= '0;
      end else begin
        if (stb.dirWr[p]) dirR[p] <= wrData & PMASK;
        if (stb.datWr[p]) datR[p] <= wrData & PMASK;
        if (stb.invWr[p]) invR[p] <= wrData & PMASK;
      end
    end

    assign portEn[p] = enR[p/2][enBit(p)];
    assign ppSel[p]  = drvInRoute(p) ? routeR[drvBit(p)] : drvHiR[drvBit(p)];

    always_comb begin
      shareMask = {PORT_W{1'b1}};
      if (p == 0)
        shareMask = {PORT_W{routeR[1:0] == ROUTE_GPIO}};
      else if (p == 1 && i2cR[1])
        shareMask = ~PORT_W'(8'h60);
      else if (p == NUM_PORTS - 1 && floppyR[1])
        shareMask = '0;
    end

    assign avail = {PORT_W{portEn[p]}} & PMASK & shareMask;
    assign drv   = datR[p] ^ invR[p];
    assign isOut = ~dirR[p] & avail;

    assign pinOe[p*PORT_W +: PORT_W]  = ppSel[p] ? isOut : (isOut & ~drv);
    assign pinOut[p*PORT_W +: PORT_W] = ppSel[p] ? (isOut & drv) : '0;
    assign datRd[p] = avail & ((dirR[p] & (pinIn[p*PORT_W +: PORT_W] ^ invR[p]))
                               | (~dirR[p] & datR[p]));

    // R6
    port_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !portEn[p] |-> (pinOe[p*PORT_W +: PORT_W] == '0));

    // R4
    open_drain_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      !ppSel[p] |-> (pinOut[p*PORT_W +: PORT_W] == '0));
  end

  always_comb begin
    rdData = '0;
    case (rdSel.kind)
      RD_DIR:  rdData = dirR[rdSel.port];
      RD_DAT:  rdData = datRd[rdSel.port];
      RD_INV:  rdData = invR[rdSel.port];
      RD_EN:   rdData = enR[rdSel.dev];
      RD_GLOB: begin
        case (rdSel.glob)
          2'd0:    rdData = floppyR;
          2'd1:    rdData = drvHiR;
          2'd2:    rdData = i2cR;
          default: rdData = routeR;
        endcase
      end
      default: rdData = '0;
    endcase
  end

  // R2
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R8
  i2c_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    i2cR[1] |-> (pinOe[PORT_W+6 -: 2] == 2'b00));

  // R9
  floppy_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    floppyR[1] |-> (pinOe[NUM_PINS-1 -: PORT_W] == '0));
endmodule

// File: rtl/sio_gpio_bank.sv
module sio_gpio_bank
  import sio_gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   devSel,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  wrStb_t stb;
  rdSel_t rdSel;

  sio_gpio_ctrl u_ctrl (
    .regAddr (regAddr),
    .devSel  (devSel),
    .wrEn    (wrEn),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  sio_gpio_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdSel  (rdSel),
    .wrData (wrData),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .rdData (rdData)
  );
endmodule

// File: tb/sio_gpio_bank_tb.sv
module sio_gpio_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [7:0]  devSel = 8'h00;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic [47:0] pinIn = '0;
  logic [47:0] pinOut, pinOe;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] g24 = 0, g29 = 0, g2a = 0, g2c = 0;
  logic [7:0] enM  [3];
  logic [7:0] dirM [6];
  logic [7:0] datM [6];
  logic [7:0] invM [6];

  always #5 clk = ~clk;

  sio_gpio_bank u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .devSel(devSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic logic [7:0] pmask(int p);
    return (p == 5) ? 8'h1F : 8'hFF;
  endfunction

  function automatic int devOf(logic [7:0] d);
    if (d == 8'h09) return 0;
    if (d == 8'h07) return 1;
    if (d == 8'h08) return 2;
    return -1;
  endfunction

  function automatic bit portOn(int p);
    case (p)
      0: return enM[0][0];
      1: return enM[0][1];
      2: return enM[1][0];
      3: return enM[1][1];
      4: return enM[2][1];
      default: return enM[2][2];
    endcase
  endfunction

  function automatic bit pushPull(int p);
    case (p)
      0: return g2c[6];
      1: return g2c[7];
      2: return g29[3];
      3: return g29[4];
      4: return g29[5];
      default: return g29[7];
    endcase
  endfunction

  function automatic logic [7:0] availOf(int p);
    logic [7:0] m;
    m = portOn(p) ? pmask(p) : 8'h00;
    if (p == 0 && g2c[1:0] != 2'd2) m = 8'h00;
    if (p == 1 && g2a[1]) m = m & 8'h9F;
    if (p == 5 && g24[1]) m = 8'h00;
    return m;
  endfunction

  function automatic logic [7:0] expOe(int p);
    logic [7:0] o;
    o = ~dirM[p] & availOf(p);
    return pushPull(p) ? o : (o & ~(datM[p] ^ invM[p]));
  endfunction

  function automatic logic [7:0] expOut(int p);
    return pushPull(p) ? (~dirM[p] & availOf(p) & (datM[p] ^ invM[p])) : 8'h00;
  endfunction

  function automatic logic [7:0] expRead(logic [7:0] a, logic [7:0] d);
    int dv;
    int p;
    logic [7:0] lvl;
    dv = devOf(d);
    if (dv >= 0 && a[7:3] == 5'b11100 && a[1:0] != 2'b11) begin
      p = dv * 2 + int'(a[2]);
      lvl = pinIn[p*8 +: 8];
      case (a[1:0])
        2'd0: return dirM[p];
        2'd1: return availOf(p) & ((dirM[p] & (lvl ^ invM[p])) | (~dirM[p] & datM[p]));
        default: return invM[p];
      endcase
    end
    if (dv >= 0 && a == 8'h30) return enM[dv];
    case (a)
      8'h24: return g24;
      8'h29: return g29;
      8'h2A: return g2a;
      8'h2C: return g2c;
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelWrite(logic [7:0] a, logic [7:0] d, logic [7:0] v);
    int dv;
    int p;
    dv = devOf(d);
    if (dv >= 0 && a[7:3] == 5'b11100 && a[1:0] != 2'b11) begin
      p = dv * 2 + int'(a[2]);
      case (a[1:0])
        2'd0: dirM[p] = v & pmask(p);
        2'd1: datM[p] = v & pmask(p);
        default: invM[p] = v & pmask(p);
      endcase
    end else if (dv >= 0 && a == 8'h30) enM[dv] = v;
    else begin
      case (a)
        8'h24: g24 = v;
        8'h29: g29 = v;
        8'h2A: g2a = v;
        8'h2C: g2c = v;
        default: ;
      endcase
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d, logic [7:0] v);
    @(negedge clk);
    regAddr = a; devSel = d; wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d, v);
  endtask

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busRead(logic [7:0] a, logic [7:0] d, string req);
    regAddr = a; devSel = d;
    #1;
    check8(req, rdData, expRead(a, d));
  endtask

  task automatic checkPins(string req);
    #1;
    for (int p = 0; p < 6; p++) begin
      check8({req, " oe"}, pinOe[p*8 +: 8], expOe(p));
      check8({req, " out"}, pinOut[p*8 +: 8], expOut(p));
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin
      dirM[i] = pmask(i); datM[i] = 0; invM[i] = 0;
    end
    for (int i = 0; i < 3; i++) enM[i] = 0;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [7:0] addrs [14];
    logic [7:0] devs  [5];
    void'($urandom(32'h5EED_1234));
    addrs = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE6, 8'hE7,
              8'h30, 8'h24, 8'h29, 8'h2A, 8'h2C, 8'h31};
    devs  = '{8'h09, 8'h07, 8'h08, 8'h05, 8'h09};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check8("R1 oe low", pinOe[7:0] | pinOe[47:40], 8'h00);
    regAddr = 8'hE0; devSel = 8'h09; #1; check8("R1 dir reset", rdData, 8'hFF);
    regAddr = 8'hE4; devSel = 8'h08; #1; check8("R10 dir reset", rdData, 8'h1F);
    regAddr = 8'h2C; devSel = 8'h09; #1; check8("R1 route reset", rdData, 8'h00);
    checkPins("R1");

    // R3 R7 port 1 push-pull through routing values
    busWrite(8'h30, 8'h09, 8'h01);
    busWrite(8'hE0, 8'h09, 8'h00);
    busWrite(8'hE1, 8'h09, 8'hA5);
    busWrite(8'h2C, 8'h09, 8'h42);
    #1; check8("R3 pp oe", pinOe[7:0], 8'hFF); check8("R3 pp out", pinOut[7:0], 8'hA5);
    for (int r = 0; r < 4; r++) begin
      busWrite(8'h2C, 8'h09, 8'h40 | 8'(r));
      checkPins("R7");
      busRead(8'hE1, 8'h09, "R7 read");
    end
    // R4 open drain with inversion
    busWrite(8'h2C, 8'h09, 8'h02);
    #1; check8("R4 od oe", pinOe[7:0], 8'h5A); check8("R4 od out", pinOut[7:0], 8'h00);
    busWrite(8'hE2, 8'h09, 8'h0F);
    #1; check8("R4 od inv oe", pinOe[7:0], 8'h55);
    // R5 input readback
    busWrite(8'hE0, 8'h09, 8'hFF);
    pinIn[7:0] = 8'h3C;
    regAddr = 8'hE1; devSel = 8'h09; #1; check8("R5 input read", rdData, 8'h33);
    // R8 I2C claim on port 2
    busWrite(8'h30, 8'h09, 8'h03);
    busWrite(8'hE4, 8'h09, 8'h00);
    busWrite(8'hE5, 8'h09, 8'hFF);
    busWrite(8'h2C, 8'h09, 8'h82);
    #1; check8("R8 before", pinOe[15:8], 8'hFF);
    busWrite(8'h2A, 8'h09, 8'h02);
    #1; check8("R8 claimed", pinOe[15:8], 8'h9F);
    busRead(8'hE5, 8'h09, "R8 read");
    // R9 R10 port 6
    busWrite(8'h30, 8'h08, 8'h04);
    busWrite(8'hE4, 8'h08, 8'h00);
    busWrite(8'hE5, 8'h08, 8'hFF);
    busWrite(8'h29, 8'h05, 8'h80);
    #1; check8("R10 five pins", pinOe[47:40], 8'h1F);
    busRead(8'hE5, 8'h08, "R10 data read");
    busWrite(8'h24, 8'h3A, 8'h02);
    #1; check8("R9 floppy", pinOe[47:40], 8'h00);
    busRead(8'h24, 8'h00, "R11 global any device");
    // R6 disabled port
    busWrite(8'h30, 8'h09, 8'h00);
    checkPins("R6");
    busRead(8'hE5, 8'h09, "R6 read");
    // R2 unmapped device and reserved slot
    busWrite(8'hE1, 8'h05, 8'h77);
    busWrite(8'hE3, 8'h07, 8'h77);
    busRead(8'hE1, 8'h05, "R2 bad device");
    busRead(8'hE3, 8'h07, "R2 reserved");
    busRead(8'hE1, 8'h07, "R2 untouched");

    // Random mix
    for (int n = 0; n < 800; n++) begin
      pinIn = {$urandom, $urandom};
      busWrite(addrs[$urandom % 14], devs[$urandom % 5], 8'($urandom));
      checkPins("R3/R4 random drive");
      busRead(addrs[$urandom % 14], devs[$urandom % 5], "R2/R5 random read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule